// File: doc/BRIEF.md
# Filter Coefficient RAM Access Controller

This block moves 24-bit filter coefficients between a small bank of byte-wide staging registers and a synchronous single-port coefficient RAM. A host reaches the staging bytes, a RAM base index and a command register over a simple byte register bus. Writing a command starts a transfer of either one coefficient or a full five-coefficient biquad set, in either direction.

For a set transfer the controller produces RAM addresses as consecutive offsets from the base index. A write transfer copies staging values into RAM. A read transfer fills the staging bytes from RAM, so the host can fetch them over the register bus afterwards. Coefficients are signed fractions (0x800000 is -1, 0x7FFFFF is just below +1) and are carried bit-exact. One RAM cycle is spent per coefficient. A busy flag locks the register bank until the transfer finishes, and a one-cycle done pulse marks its end.

Top module: `coef_ram_ctrl`

## Requirements
- R1: After reset the base index, all fifteen staging bytes and the control register read 0, busy_o and done_o are low, and the RAM port issues no access.
- R2: Register address 0 holds the base index (its low ADDR_W bits). Register 1+3*s+b holds byte b of slot s, with b=0 the most significant byte. Slots s=0..4 are, in order, b1, b2, a1, a2, b0. Every staging byte and the base read back what was written.
- R3: Control bit 0 (write-one) writes slot 0 to RAM address base in exactly one RAM cycle and touches no other address.
- R4: Control bit 1 (write-all) writes slot k to RAM address (base+k) mod 2^ADDR_W for k=0..4, on consecutive cycles in increasing k.
- R5: Control bit 2 (read-one) loads RAM[base] into slot 0 and leaves slots 1..4 unchanged.
- R6: Control bit 3 (read-all) loads RAM[(base+k) mod 2^ADDR_W] into slot k for k=0..4.
- R7: Control register reads return the accepted command bit in bits 3:0 and busy in bit 7 while a transfer runs, and 0 once it ends. When several command bits are written at once, the lowest-numbered one is taken. Writing no command bit starts nothing.
- R8: busy_o stays high for N cycles after a write command is accepted and for N+1 cycles after a read command, where N is 1 or 5. done_o pulses for one cycle in the first cycle with busy_o low.
- R9: While busy_o is high, register writes to the base, the staging bytes and the control register have no effect.
- R10: The extreme fraction values 0x800000 and 0x7FFFFF pass through a write-all and a read-all round trip unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_rdata_i | input | DATA_W | RAM read data, valid the cycle after a read access |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer ends |

## Verification
The assertions check on every cycle that the RAM port is used only while busy, that addresses within a transfer step by one modulo the RAM depth, that the direction never changes mid-transfer, and that done_o is a single pulse on the falling edge of busy. Which slot lands at which address, whether read data reaches the right staging bytes, the command priority and the locking out of host writes during a transfer can only be shown by the bench's scenarios. These scenarios compare a RAM model and the register readback against expected values, including base indices that wrap past the top of the RAM.

// File: rtl/coef_pkg.sv
package coef_pkg;
  parameter int unsigned COEF_SLOTS = 5;
  parameter int unsigned REG_DW     = 8;
  parameter int unsigned CTRL_BUSY  = 7;

  typedef enum logic [1:0] {
    CMD_WR_ONE = 2'd0,
    CMD_WR_ALL = 2'd1,
    CMD_RD_ONE = 2'd2,
    CMD_RD_ALL = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/coef_regfile.sv
module coef_regfile
  import coef_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned REG_AW = 5,
  localparam int unsigned IDX_W = $clog2(COEF_SLOTS)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  reg_we_i,
  input  logic [REG_AW-1:0]                     reg_addr_i,
  input  logic [REG_DW-1:0]                     reg_wdata_i,
  output logic [REG_DW-1:0]                     reg_rdata_o,
  input  logic                                  busy_i,
  input  logic                                  cap_vld_i,
  input  logic [IDX_W-1:0]                      cap_idx_i,
  input  logic [DATA_W-1:0]                     cap_data_i,
  output logic                                  start_o,
  output cmd_e                                  cmd_o,
  output logic [ADDR_W-1:0]                     base_o,
  output logic [COEF_SLOTS-1:0][DATA_W-1:0]     slots_o
);
  localparam int unsigned BPC      = DATA_W / REG_DW;
  localparam int unsigned NBYTE    = COEF_SLOTS * BPC;
  localparam int unsigned ADR_BASE = 0;
  localparam int unsigned ADR_STG0 = 1;
  localparam int unsigned ADR_CTRL = ADR_STG0 + NBYTE;

  logic [ADDR_W-1:0] base_q;
  logic [REG_DW-1:0] stg_q [NBYTE];
  logic [3:0]        ctrl_q;
  logic              host_wr;

  assign host_wr = reg_we_i && !busy_i;
  assign start_o = host_wr && (reg_addr_i == REG_AW'(ADR_CTRL)) && |reg_wdata_i[3:0];

  // lowest command bit wins
  always_comb begin
    if (reg_wdata_i[0])      cmd_o = CMD_WR_ONE;
    else if (reg_wdata_i[1]) cmd_o = CMD_WR_ALL;
    else if (reg_wdata_i[2]) cmd_o = CMD_RD_ONE;
    else                     cmd_o = CMD_RD_ALL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (host_wr && reg_addr_i == REG_AW'(ADR_BASE)) base_q <= reg_wdata_i[ADDR_W-1:0];
      if (start_o) ctrl_q <= 4'b0001 << cmd_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBYTE; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NBYTE; i++) begin
        if (host_wr && reg_addr_i == REG_AW'(ADR_STG0 + i))
          stg_q[i] <= reg_wdata_i;
        else if (cap_vld_i && cap_idx_i == IDX_W'(i / BPC))
          stg_q[i] <= cap_data_i[DATA_W-1-REG_DW*(i % BPC) -: REG_DW];
      end
    end
  end

  for (genvar s = 0; s < COEF_SLOTS; s++) begin : g_slot
    for (genvar b = 0; b < BPC; b++) begin : g_byte
      assign slots_o[s][DATA_W-1-REG_DW*b -: REG_DW] = stg_q[s*BPC+b];
    end
  end

  assign base_o = base_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == REG_AW'(ADR_BASE)) reg_rdata_o[ADDR_W-1:0] = base_q;
    for (int i = 0; i < NBYTE; i++)
      if (reg_addr_i == REG_AW'(ADR_STG0 + i)) reg_rdata_o = stg_q[i];
    if (reg_addr_i == REG_AW'(ADR_CTRL)) begin
      reg_rdata_o[3:0]       = busy_i ? ctrl_q : 4'b0000;
      reg_rdata_o[CTRL_BUSY] = busy_i;
    end
  end
endmodule

// File: rtl/coef_seq.sv
module coef_seq
  import coef_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 24,
  localparam int unsigned IDX_W = $clog2(COEF_SLOTS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  cmd_e                              cmd_i,
  input  logic [ADDR_W-1:0]                 base_i,
  input  logic [COEF_SLOTS-1:0][DATA_W-1:0] slots_i,
  output logic                              ram_en_o,
  output logic                              ram_we_o,
  output logic [ADDR_W-1:0]                 ram_addr_o,
  output logic [DATA_W-1:0]                 ram_wdata_o,
  input  logic [DATA_W-1:0]                 ram_rdata_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic                              cap_vld_o,
  output logic [IDX_W-1:0]                  cap_idx_o,
  output logic [DATA_W-1:0]                 cap_data_o
);
  localparam logic [IDX_W-1:0] LAST_ALL = IDX_W'(COEF_SLOTS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             rd_q, at_last;

  assign at_last = (idx_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      last_q    <= '0;
      rd_q      <= 1'b0;
      done_o    <= 1'b0;
      cap_vld_o <= 1'b0;
      cap_idx_o <= '0;
    end else begin
      done_o    <= (state_q == ST_RUN && at_last && !rd_q) || state_q == ST_DRAIN;
      cap_vld_o <= ram_en_o && !ram_we_o;
      cap_idx_o <= idx_q;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          idx_q   <= '0;
          last_q  <= (cmd_i == CMD_WR_ALL || cmd_i == CMD_RD_ALL) ? LAST_ALL : '0;
          rd_q    <= (cmd_i == CMD_RD_ONE || cmd_i == CMD_RD_ALL);
        end
        ST_RUN: begin
          if (at_last) state_q <= rd_q ? ST_DRAIN : ST_IDLE;
          else         idx_q   <= idx_q + 1'b1;
        end
        ST_DRAIN: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_en_o    = (state_q == ST_RUN);
    ram_we_o    = ram_en_o && !rd_q;
    ram_addr_o  = base_i + ADDR_W'(idx_q);
    ram_wdata_o = '0;
    if (ram_we_o && idx_q < IDX_W'(COEF_SLOTS)) ram_wdata_o = slots_i[idx_q];
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign cap_data_o = ram_rdata_i;
endmodule

// File: rtl/coef_ram_ctrl.sv
module coef_ram_ctrl
  import coef_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned IDX_W = $clog2(COEF_SLOTS);

  logic                              start, cap_vld;
  cmd_e                              cmd;
  logic [ADDR_W-1:0]                 base;
  logic [COEF_SLOTS-1:0][DATA_W-1:0] slots;
  logic [IDX_W-1:0]                  cap_idx;
  logic [DATA_W-1:0]                 cap_data;

  coef_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) i_regfile (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy_o), .cap_vld_i(cap_vld), .cap_idx_i(cap_idx), .cap_data_i(cap_data),
    .start_o(start), .cmd_o(cmd), .base_o(base), .slots_o(slots)
  );

  coef_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(cmd), .base_i(base), .slots_i(slots),
    .ram_en_o, .ram_we_o, .ram_addr_o, .ram_wdata_o, .ram_rdata_i,
    .busy_o, .done_o, .cap_vld_o(cap_vld), .cap_idx_o(cap_idx), .cap_data_o(cap_data)
  );
endmodule

// File: rtl/coef_ram_ctrl_chk.sv
module coef_ram_ctrl_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ram_en_o,
  input logic              ram_we_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              busy_o,
  input logic              done_o
);
  AST_EN_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) ram_en_o |-> busy_o); // R8
  AST_BUSY_STARTS_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(busy_o) |-> ram_en_o); // R8
  AST_ADDR_CONSEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o && $past(ram_en_o) |-> ram_addr_o == ADDR_W'($past(ram_addr_o) + 1'b1)); // R4
  AST_DIR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o && $past(ram_en_o) |-> ram_we_o == $past(ram_we_o)); // R6
  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R8
endmodule

bind coef_ram_ctrl coef_ram_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i, .rst_ni, .ram_en_o, .ram_we_o, .ram_addr_o, .busy_o, .done_o
);

// File: tb/test_coef_ram_ctrl.sv
`timescale 1ns/1ps
module test_coef_ram_ctrl;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 24;
  localparam int REG_AW = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int ADR_CTRL = 16;

  logic clk_i = 0, rst_ni = 0;
  logic reg_we_i = 0;
  logic [REG_AW-1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic ram_en_o, ram_we_o, busy_o, done_o;
  logic [ADDR_W-1:0] ram_addr_o;
  logic [DATA_W-1:0] ram_wdata_o, ram_rdata_i;

  int n_chk = 0, n_fail = 0, en_cnt = 0;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] exp_slot [5];

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (ram_en_o) begin
      en_cnt <= en_cnt + 1;
      if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
      else ram_rdata_i <= mem[ram_addr_o];
    end
  end

  coef_ram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) i_coef_ram_ctrl (.*);

  function automatic int wrap(int b, int k);
    return (b + k) % DEPTH;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(int a, logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = REG_AW'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic reg_rd(int a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = REG_AW'(a);
    #1 d = reg_rdata_o;
  endtask

  task automatic set_coef(int s, logic [DATA_W-1:0] v);
    reg_wr(1 + 3*s, v[23:16]);
    reg_wr(2 + 3*s, v[15:8]);
    reg_wr(3 + 3*s, v[7:0]);
  endtask

  task automatic get_coef(int s, output logic [DATA_W-1:0] v);
    logic [7:0] b;
    reg_rd(1 + 3*s, b); v[23:16] = b;
    reg_rd(2 + 3*s, b); v[15:8]  = b;
    reg_rd(3 + 3*s, b); v[7:0]   = b;
  endtask

  // issue a command, read control in the first busy cycle, count busy cycles
  task automatic issue(logic [7:0] c, output int n, output logic dn, output logic [7:0] ctl);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = REG_AW'(ADR_CTRL); reg_wdata_i = c;
    @(negedge clk_i);
    reg_we_i = 0;
    #1 ctl = reg_rdata_o;
    n = 0; dn = 0;
    while (n < 50) begin
      if (busy_o) n++;
      else begin dn = done_o; break; end
      @(negedge clk_i);
    end
  endtask

  initial begin
    int n, e0, b;
    logic dn;
    logic [7:0] ctl, rb;
    logic [DATA_W-1:0] v;
    void'($urandom(32'd7301));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    ram_rdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    for (int a = 0; a <= ADR_CTRL; a++) begin
      reg_rd(a, rb); check(rb == 0, "R1 reg after reset", rb, 0);
    end
    check(!busy_o && !done_o && en_cnt == 0, "R1 idle port", en_cnt, 0);

    // R2 readback of base and staging
    reg_wr(0, 8'hE5); reg_rd(0, rb); check(rb == 8'h25, "R2 base low bits", rb, 8'h25);
    for (int s = 0; s < 5; s++) begin
      v = $urandom; exp_slot[s] = v; set_coef(s, v);
    end
    for (int s = 0; s < 5; s++) begin
      get_coef(s, v); check(v == exp_slot[s], "R2 staging readback", v, exp_slot[s]);
    end

    // R3 write-one
    e0 = en_cnt;
    issue(8'h01, n, dn, ctl);
    check(n == 1, "R8 write-one busy cycles", n, 1);
    check(dn, "R8 done pulse", dn, 1);
    check(ctl == 8'h81, "R7 control during write-one", ctl, 8'h81);
    check(en_cnt - e0 == 1, "R3 single RAM access", en_cnt - e0, 1);
    check(mem[37] == exp_slot[0], "R3 slot b1 at base", mem[37], exp_slot[0]);
    check(mem[38] == 0, "R3 next address untouched", mem[38], 0);
    reg_rd(ADR_CTRL, rb); check(rb == 0, "R7 control clears", rb, 0);

    // R4 write-all with wrap, priority of two bits (R7)
    reg_wr(0, 8'd62);
    e0 = en_cnt;
    issue(8'h0A, n, dn, ctl);
    check(ctl == 8'h82, "R7 lowest bit wins", ctl, 8'h82);
    check(n == 5, "R8 write-all busy cycles", n, 5);
    check(dn, "R8 done pulse", dn, 1);
    check(en_cnt - e0 == 5, "R4 five accesses", en_cnt - e0, 5);
    for (int k = 0; k < 5; k++)
      check(mem[wrap(62, k)] == exp_slot[k], "R4 slot at base+k wrapped", mem[wrap(62, k)], exp_slot[k]);

    // R7 no command bit starts nothing
    e0 = en_cnt;
    reg_wr(ADR_CTRL, 8'hF0);
    @(negedge clk_i);
    check(!busy_o && en_cnt == e0, "R7 empty command ignored", en_cnt - e0, 0);

    // R5 read-one
    mem[10] = 24'h123456; mem[11] = 24'h654321;
    reg_wr(0, 8'd10);
    issue(8'h04, n, dn, ctl);
    check(n == 2, "R8 read-one busy cycles", n, 2);
    check(dn, "R8 done pulse", dn, 1);
    get_coef(0, v); check(v == 24'h123456, "R5 slot 0 loaded", v, 24'h123456);
    get_coef(1, v); check(v == exp_slot[1], "R5 slot 1 unchanged", v, exp_slot[1]);
    exp_slot[0] = 24'h123456;

    // R10 extreme fractions round trip
    set_coef(0, 24'h800000); set_coef(4, 24'h7FFFFF);
    reg_wr(0, 8'd20);
    issue(8'h02, n, dn, ctl);
    set_coef(0, 24'h0); set_coef(4, 24'h0);
    issue(8'h08, n, dn, ctl);
    check(n == 6, "R8 read-all busy cycles", n, 6);
    get_coef(0, v); check(v == 24'h800000, "R10 minus one", v, 24'h800000);
    get_coef(4, v); check(v == 24'h7FFFFF, "R10 max positive", v, 24'h7FFFFF);

    // R9 writes during busy ignored
    for (int k = 0; k < 5; k++) mem[wrap(40, k)] = $urandom;
    reg_wr(0, 8'd40);
    e0 = en_cnt;
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = REG_AW'(ADR_CTRL); reg_wdata_i = 8'h08;
    @(negedge clk_i); reg_addr_i = 5'd1;  reg_wdata_i = 8'hAA;
    @(negedge clk_i); reg_addr_i = 5'd0;  reg_wdata_i = 8'd3;
    @(negedge clk_i); reg_addr_i = REG_AW'(ADR_CTRL); reg_wdata_i = 8'h01;
    @(negedge clk_i); reg_we_i = 0;
    while (busy_o) @(negedge clk_i);
    reg_rd(0, rb); check(rb == 40, "R9 base kept", rb, 40);
    check(en_cnt - e0 == 5, "R9 no extra transfer", en_cnt - e0, 5);
    for (int k = 0; k < 5; k++) begin
      get_coef(k, v); check(v == mem[wrap(40, k)], "R6 slot from base+k", v, mem[wrap(40, k)]);
    end

    // random round trips
    for (int it = 0; it < 20; it++) begin
      b = $urandom_range(DEPTH - 1);
      reg_wr(0, 8'(b));
      for (int s = 0; s < 5; s++) begin exp_slot[s] = $urandom; set_coef(s, exp_slot[s]); end
      issue(8'h02, n, dn, ctl);
      for (int k = 0; k < 5; k++)
        check(mem[wrap(b, k)] == exp_slot[k], "R4 random write-all", mem[wrap(b, k)], exp_slot[k]);
      for (int s = 0; s < 5; s++) set_coef(s, $urandom);
      issue(8'h08, n, dn, ctl);
      check(n == 6 && dn, "R8 random read-all timing", n, 6);
      for (int s = 0; s < 5; s++) begin
        get_coef(s, v); check(v == exp_slot[s], "R6 random read-all", v, exp_slot[s]);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule